// File: doc/BRIEF.md
# Master Clock Rate Selector

This block sits in the clock front end of a voice codec. It watches one multi-purpose select pin and decides which master-clock rate the internal divider works from. It also decides which bit clock feeds the receive path. The pin can be tied low, tied high, or driven with a running clock. An activity detector looks at the pin over a fixed window of master-clock cycles and sorts it into one of those three states. A lookup that depends on the device variant then turns that state into a rate decision: either the 2.048 MHz family or the 1.536/1.544 MHz family.

The decision is not used at once. It is held pending and copied into the working mode only on a frame-sync cycle, so the divider never changes ratio in the middle of a frame. The divider produces a common internal clock enable of 192 pulses per 125 us frame from any of the master-clock rates:
- At 2.048 MHz it drops one cycle in every four.
- At 1.536 MHz it passes every cycle.
- At 1.544 MHz it drops the extra 193rd cycle of each frame.

When the pin is running as a clock, it is also passed through as the receive bit clock. Otherwise the transmit bit clock serves both directions.

Top module: `mclk_rate_sel`

## Requirements
- R1: The pin is synchronised and judged once per window of WIN master-clock cycles. `pin_state` becomes 2 (clocked) if two or more synchronised edges fall inside the window. Otherwise it becomes the synchronised level at the window's last cycle: 0 for low, 1 for high. A single transition, or edges spaced WIN or more cycles apart, never yields 2.
- R2: With VARIANT=0, the state-to-rate map is: low gives `rate_2048`=0; high gives 1; clocked gives 1.
- R3: With VARIANT=1, the map is inverted: low gives `rate_2048`=1; high gives 0; clocked gives 0.
- R4: `rx_from_pin` is 1 exactly when the applied state is clocked. `rx_bclk` is a register with two sources:
  - When routing is 1, it takes the pin value driven two edges before the sampling edge.
  - When routing is 0, it takes `bclk_tx` from the previous cycle.
- R5: `rate_2048` and `rx_from_pin` change only on the edge that samples `frame_sync` high. A change of `pin_state` in between has no effect on them.
- R6: The frame index is 0 on a cycle with `frame_sync` high. It then increments each cycle, and it wraps from FRAME_MAX-1 to 0 when no sync arrives. `clk_en` shows the gate result for a given index one edge after that index is sampled.
- R7: With `rate_2048`=1, `clk_en` is high for every index whose value modulo 4 is not 3. A 256-cycle frame therefore gives 192 enables.
- R8: With `rate_2048`=0, `clk_en` is high for every index except 192, which is the 193rd cycle. Frames of 192 and of 193 cycles both give 192 enables.
- R9: While `rst` is high, the outputs take these values:
  - `pin_state`=0, `rx_from_pin`=0, `rx_bclk`=0 and `clk_en`=0.
  - `rate_2048` is the map of the low state: 0 for VARIANT=0 and 1 for VARIANT=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_pin | input | 1 | Multi-purpose select pin (static level or receive bit clock) |
| frame_sync | input | 1 | One-cycle frame boundary strobe, synchronous to clk |
| bclk_tx | input | 1 | Transmit bit clock level, sampled on clk |
| pin_state | output | 2 | Judged pin state: 0 low, 1 high, 2 clocked |
| rate_2048 | output | 1 | Applied rate: 1 for 2.048 MHz, 0 for 1.536/1.544 MHz |
| rx_from_pin | output | 1 | Applied routing: 1 when the pin is the receive bit clock |
| rx_bclk | output | 1 | Registered receive bit clock |
| clk_en | output | 1 | Internal divider clock enable, 192 per frame |

## Verification
The assertions take certain things about the inputs for granted:
- `frame_sync` is a clean strobe in the master-clock domain.
- The gap between two syncs never exceeds FRAME_MAX cycles without a wrap.

Under those conditions, every enable gap lasts one cycle, and the cycle after a sync always carries an enable. The stimulus drives every input just after a rising edge, and it always starts a frame with a single sync cycle. The pin patterns it uses stay clearly on one side of the activity threshold:
- fixed levels,
- a period-4 toggle,
- a toggle with half-period WIN.

Frame lengths are 192, 193, 200 and 256 cycles, plus a long run without any sync, so the wrap stays inside the assumed range.

// File: rtl/mrs_pkg.sv
package mrs_pkg;

  typedef enum logic [1:0] {
    PIN_LOW     = 2'd0,
    PIN_HIGH    = 2'd1,
    PIN_CLOCKED = 2'd2
  } pin_state_e;

  // Rate decision per device variant; 1 selects the 2.048 MHz family.
  function automatic logic rate_lookup(input logic variant, input pin_state_e st);
    logic r;
    if (!variant) r = (st != PIN_LOW);
    else          r = (st == PIN_LOW);
    return r;
  endfunction

endpackage

// File: rtl/mrs_activity.sv
module mrs_activity
  import mrs_pkg::*;
#(
  parameter int WIN         = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pin_async,
  output logic       pin_sync,
  output pin_state_e state
);

  localparam int WW = (WIN > 1) ? $clog2(WIN) : 1;

  logic [SYNC_STAGES-1:0] chain;

  // synchroniser stages built one flop per stage
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[0] <= 1'b0;
        else     chain[0] <= pin_async;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= 1'b0;
        else     chain[g] <= chain[g-1];
      end
    end
  end

  assign pin_sync = chain[SYNC_STAGES-1];

  logic          last_lvl;
  logic          edge_hit;
  logic [1:0]    edge_cnt;
  logic [1:0]    edge_next;
  logic [WW-1:0] win_cnt;
  logic          win_end;

  assign edge_hit = pin_sync ^ last_lvl;
  assign win_end  = (win_cnt == WW'(WIN - 1));

  always_comb begin
    edge_next = edge_cnt;
    if (edge_hit && (edge_cnt != 2'd2)) edge_next = edge_cnt + 2'd1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_lvl <= 1'b0;
      edge_cnt <= 2'd0;
      win_cnt  <= '0;
      state    <= PIN_LOW;
    end else begin
      last_lvl <= pin_sync;
      if (win_end) begin
        win_cnt  <= '0;
        edge_cnt <= 2'd0;
        if (edge_next == 2'd2) state <= PIN_CLOCKED;
        else if (pin_sync)     state <= PIN_HIGH;
        else                   state <= PIN_LOW;
      end else begin
        win_cnt  <= win_cnt + 1'b1;
        edge_cnt <= edge_next;
      end
    end
  end

endmodule

// File: rtl/mrs_mode_reg.sv
module mrs_mode_reg
  import mrs_pkg::*;
#(
  parameter bit VARIANT = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       frame_sync,
  input  pin_state_e state,
  output logic       rate_2048,
  output logic       route_pin
);

  logic rate_pend;
  logic route_pend;

  always_comb begin
    rate_pend  = rate_lookup(VARIANT, state);
    route_pend = (state == PIN_CLOCKED);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rate_2048 <= rate_lookup(VARIANT, PIN_LOW);
      route_pin <= 1'b0;
    end else if (frame_sync) begin
      rate_2048 <= rate_pend;
      route_pin <= route_pend;
    end
  end

endmodule

// File: rtl/mrs_frame_div.sv
module mrs_frame_div #(
  parameter int FRAME_MAX   = 256,
  parameter int T1_SKIP_IDX = 192,
  parameter int HI_PHASES   = 4,
  parameter int HI_KEEP     = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic frame_sync,
  input  logic rate_2048,
  output logic clk_en
);

  localparam int IW = $clog2(FRAME_MAX);
  localparam int PW = (HI_PHASES > 1) ? $clog2(HI_PHASES) : 1;

  logic [IW-1:0] fcnt;
  logic [IW-1:0] idx;
  logic          gate_hi;
  logic          gate_lo;

  always_comb begin
    idx     = frame_sync ? '0 : fcnt;
    gate_hi = (idx[PW-1:0] < PW'(HI_KEEP));
    gate_lo = (idx != IW'(T1_SKIP_IDX));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fcnt   <= '0;
      clk_en <= 1'b0;
    end else begin
      fcnt   <= (idx == IW'(FRAME_MAX - 1)) ? '0 : idx + 1'b1;
      clk_en <= rate_2048 ? gate_hi : gate_lo;
    end
  end

endmodule

// File: rtl/mclk_rate_sel.sv
module mclk_rate_sel
  import mrs_pkg::*;
#(
  parameter bit VARIANT     = 1'b0,
  parameter int WIN         = 64,
  parameter int SYNC_STAGES = 2,
  parameter int FRAME_MAX   = 256,
  parameter int T1_SKIP_IDX = 192,
  parameter int HI_PHASES   = 4,
  parameter int HI_KEEP     = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sel_pin,
  input  logic       frame_sync,
  input  logic       bclk_tx,
  output logic [1:0] pin_state,
  output logic       rate_2048,
  output logic       rx_from_pin,
  output logic       rx_bclk,
  output logic       clk_en
);

  pin_state_e st;
  logic       pin_s;

  mrs_activity #(
    .WIN         (WIN),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_act (
    .clk       (clk),
    .rst       (rst),
    .pin_async (sel_pin),
    .pin_sync  (pin_s),
    .state     (st)
  );

  assign pin_state = st;

  mrs_mode_reg #(
    .VARIANT (VARIANT)
  ) u_mode (
    .clk        (clk),
    .rst        (rst),
    .frame_sync (frame_sync),
    .state      (st),
    .rate_2048  (rate_2048),
    .route_pin  (rx_from_pin)
  );

  mrs_frame_div #(
    .FRAME_MAX   (FRAME_MAX),
    .T1_SKIP_IDX (T1_SKIP_IDX),
    .HI_PHASES   (HI_PHASES),
    .HI_KEEP     (HI_KEEP)
  ) u_div (
    .clk        (clk),
    .rst        (rst),
    .frame_sync (frame_sync),
    .rate_2048  (rate_2048),
    .clk_en     (clk_en)
  );

  always_ff @(posedge clk) begin
    if (rst) rx_bclk <= 1'b0;
    else     rx_bclk <= rx_from_pin ? pin_s : bclk_tx;
  end

endmodule

// File: rtl/mclk_rate_sel_chk.sv
module mclk_rate_sel_chk #(
  parameter bit VARIANT = 1'b0
) (
  input logic       clk,
  input logic       rst,
  input logic       frame_sync,
  input logic       bclk_tx,
  input logic [1:0] pin_state,
  input logic       rate_2048,
  input logic       rx_from_pin,
  input logic       rx_bclk,
  input logic       clk_en
);

  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    pin_state != 2'd3);  // R1

  AST_ROUTE_RATE_PAIR: assert property (@(posedge clk) disable iff (rst)
    rx_from_pin |-> (rate_2048 == !VARIANT));  // R2

  AST_RX_FROM_TX: assert property (@(posedge clk) disable iff (rst)
    !rx_from_pin |=> (rx_bclk == $past(bclk_tx)));  // R4

  AST_RATE_FRAME_ONLY: assert property (@(posedge clk) disable iff (rst)
    !frame_sync |=> $stable(rate_2048));  // R5

  AST_ROUTE_FRAME_ONLY: assert property (@(posedge clk) disable iff (rst)
    !frame_sync |=> $stable(rx_from_pin));  // R5

  AST_EN_AFTER_SYNC: assert property (@(posedge clk) disable iff (rst)
    frame_sync |=> clk_en);  // R6

  AST_EN_GAP_SINGLE: assert property (@(posedge clk) disable iff (rst)
    !clk_en |=> clk_en);  // R8

endmodule

bind mclk_rate_sel mclk_rate_sel_chk #(.VARIANT(VARIANT)) u_chk (.*);

// File: tb/tb_mclk_rate_sel.sv
`timescale 1ns/1ps
module tb_mclk_rate_sel;

  localparam int WIN       = 16;
  localparam int FRAME_MAX = 256;
  localparam int SKIP      = 192;
  localparam int MAXCYC    = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel_pin = 1'b0;
  logic frame_sync = 1'b0;
  logic bclk_tx = 1'b0;

  logic [1:0] st0, st1;
  logic rate0, rate1, rte0, rte1, rx0, rx1, en0, en1;

  always #2 clk = ~clk;

  mclk_rate_sel #(.VARIANT(1'b0), .WIN(WIN)) dut (
    .clk(clk), .rst(rst), .sel_pin(sel_pin), .frame_sync(frame_sync),
    .bclk_tx(bclk_tx), .pin_state(st0), .rate_2048(rate0),
    .rx_from_pin(rte0), .rx_bclk(rx0), .clk_en(en0));

  mclk_rate_sel #(.VARIANT(1'b1), .WIN(WIN)) dut_b (
    .clk(clk), .rst(rst), .sel_pin(sel_pin), .frame_sync(frame_sync),
    .bclk_tx(bclk_tx), .pin_state(st1), .rate_2048(rate1),
    .rx_from_pin(rte1), .rx_bclk(rx1), .clk_en(en1));

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int prev_idx = FRAME_MAX - 1;
  logic exp_en0, exp_en1, rt0, rt1, blat;
  logic [2:0] ph = 3'b000;
  int cnt0, cnt1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic logic gate(input int idx, input logic r);
    return r ? ((idx % 4) != 3) : (idx != SKIP);
  endfunction

  function automatic int exp_count(input int len, input logic r);
    int n = 0;
    for (int i = 0; i < len; i++) n += int'(gate(i, r));
    return n;
  endfunction

  function automatic logic pin_val(input int pm, input int c);
    case (pm)
      0: return 1'b0;
      1: return 1'b1;
      2: return 1'((c / 2) % 2);
      default: return 1'((c / WIN) % 2);
    endcase
  endfunction

  // Drive inputs for the coming edge and predict its results.
  task automatic drive(input logic p, input logic f, input logic b);
    int midx;
    sel_pin = p; frame_sync = f; bclk_tx = b;
    midx = f ? 0 : ((prev_idx == FRAME_MAX - 1) ? 0 : prev_idx + 1);
    prev_idx = midx;
    exp_en0 = gate(midx, rate0);
    exp_en1 = gate(midx, rate1);
    rt0 = rte0; rt1 = rte1;
    ph = {ph[1:0], p};
    blat = b;
    cyc++;
  endtask

  task automatic edge_obs();
    logic erx0, erx1;
    @(posedge clk); #1;
    chk(en0 == exp_en0, rate0 ? "R7 R6 clk_en v0" : "R8 R6 clk_en v0", en0, exp_en0);
    chk(en1 == exp_en1, rate1 ? "R7 R6 clk_en v1" : "R8 R6 clk_en v1", en1, exp_en1);
    erx0 = rt0 ? ph[2] : blat;
    erx1 = rt1 ? ph[2] : blat;
    chk(rx0 == erx0, "R4 rx_bclk v0", rx0, erx0);
    chk(rx1 == erx1, "R4 rx_bclk v1", rx1, erx1);
    cnt0 += int'(en0);
    cnt1 += int'(en1);
  endtask

  task automatic frame(input int len, input int pm);
    logic r0, r1;
    cnt0 = 0; cnt1 = 0;
    for (int i = 0; i < len; i++) begin
      drive(pin_val(pm, cyc), i == 0, 1'((cyc % 3) == 0));
      edge_obs();
      if (i == 0) begin r0 = rate0; r1 = rate1; end
    end
    chk(cnt0 == exp_count(len, r0), r0 ? "R7 frame count v0" : "R8 frame count v0", cnt0, exp_count(len, r0));
    chk(cnt1 == exp_count(len, r1), r1 ? "R7 frame count v1" : "R8 frame count v1", cnt1, exp_count(len, r1));
  endtask

  task automatic nosync(input int len, input int pm);
    for (int i = 0; i < len; i++) begin
      drive(pin_val(pm, cyc), 1'b0, 1'((cyc % 5) < 2));
      edge_obs();
    end
  endtask

  initial begin
    #(MAXCYC * 4);
    failures++;
    $display("FAIL watchdog expired after %0d cycles", MAXCYC);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1;
    // R9 reset state
    chk(st0 == 2'd0, "R9 pin_state", st0, 0);
    chk(rate0 == 1'b0, "R9 rate v0", rate0, 0);
    chk(rate1 == 1'b1, "R9 rate v1", rate1, 1);
    chk(rte0 == 1'b0 && rte1 == 1'b0, "R9 route", rte0, 0);
    chk(en0 == 1'b0 && en1 == 1'b0, "R9 clk_en", en0, 0);
    chk(rx0 == 1'b0 && rx1 == 1'b0, "R9 rx_bclk", rx0, 0);
    rst = 1'b0;

    // Low level: 1.536/1.544 for v0, 2.048 for v1
    frame(192, 0);
    frame(193, 0);
    frame(256, 0);
    chk(st0 == 2'd0, "R1 low level", st0, 0);
    chk(rate0 == 1'b0, "R2 low -> 1.5xx", rate0, 0);
    chk(rate1 == 1'b1, "R3 low -> 2.048", rate1, 1);
    chk(cnt1 == 192, "R7 256-cycle frame gives 192", cnt1, 192);
    chk(rte0 == 1'b0, "R4 fixed level uses tx clock", rte0, 0);

    // Fast toggling: classified mid-frame, applied at the next sync
    frame(256, 2);
    chk(st0 == 2'd2, "R1 fast toggle is clocked", st0, 2);
    chk(rate0 == 1'b0, "R5 rate held until sync", rate0, 0);
    chk(rte0 == 1'b0, "R5 route held until sync", rte0, 0);
    frame(256, 2);
    chk(rte0 == 1'b1 && rte1 == 1'b1, "R4 clocked pin routed", rte0, 1);
    chk(rate0 == 1'b1, "R2 clocked -> 2.048", rate0, 1);
    chk(rate1 == 1'b0, "R3 clocked -> 1.5xx", rate1, 0);
    chk(cnt0 == 192, "R7 2.048 frame gives 192", cnt0, 192);

    // Slow toggling: one edge per window, never clocked
    frame(256, 3);
    chk(st0 != 2'd2, "R1 slow toggle not clocked", st0, 0);
    frame(256, 3);
    chk(st0 != 2'd2, "R1 slow toggle not clocked", st0, 0);
    chk(rte0 == 1'b0, "R4 slow toggle uses tx clock", rte0, 0);

    // Back to low, then one rising transition to high
    frame(192, 0);
    chk(st0 == 2'd0, "R1 low again", st0, 0);
    frame(200, 1);
    chk(st0 == 2'd1, "R1 single edge gives high", st0, 1);
    chk(rate0 == 1'b0, "R5 high not yet applied", rate0, 0);
    frame(193, 1);
    chk(rate0 == 1'b1, "R2 high -> 2.048", rate0, 1);
    chk(rate1 == 1'b0, "R3 high -> 1.5xx", rate1, 0);
    chk(cnt1 == 192, "R8 193-cycle frame gives 192", cnt1, 192);

    // No sync: counter wraps on its own, mode stays put
    nosync(600, 0);
    chk(st0 == 2'd0, "R1 low during free run", st0, 0);
    chk(rate0 == 1'b1, "R5 no sync keeps rate", rate0, 1);
    frame(192, 0);
    chk(rate0 == 1'b0, "R2 low applied after sync", rate0, 0);
    chk(cnt0 == 192, "R8 192-cycle frame gives 192", cnt0, 192);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule